// File: doc/BRIEF.md
# GPIO Event Detect Interrupt Bank

This block watches one bank of up to 32 general-purpose input pins for events and turns them into a single interrupt. Each pin is brought into the clock domain through a two-flop synchroniser. Four per-pin enables arm detection of a rising edge, a falling edge, a high level and a low level, in any combination. Setting both edge enables on one pin catches every transition. A detected event sets that pin's bit in a status register. Software clears a bit by writing a one to it. The bank interrupt is high, one cycle later, whenever any status bit is set.

Edge and level events behave differently once software tries to clear them. An edge event is recorded once and stays recorded until it is cleared. A level event is re-recorded on every cycle the pin stays at the armed level, so a clear only holds after the pin has left that level. A second instance of the block can serve a partly populated bank, for example 22 pins. In that case the parameter `NUM_PRESENT` ties the missing upper pins off.

The register port has a write strobe, a 3-bit word address, 32-bit write data and combinational read data. The address map is:

| Address | Register | Access |
|---|---|---|
| 0 | rising-edge enable | read/write |
| 1 | falling-edge enable | read/write |
| 2 | high-level enable | read/write |
| 3 | low-level enable | read/write |
| 4 | status | read / write-one-to-clear |
| 5 | synchronised level | read-only |
| 6, 7 | unused | read as zero |

Pin n always maps to bit n.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset, all four enable registers and the status register read as zero, and `irq` is low.
- R2: Address 5 returns the pin levels after a two-flop synchroniser. A change on `pin_in[n]` appears in bit n two clock edges later. Writes to address 5 have no effect.
- R3: With bit n of the rising-edge enable (address 0) set, a 0-to-1 transition of the synchronised pin sets status bit n exactly once. The bit stays set while the pin stays high and after the pin falls, until software clears it.
- R4: With bit n of the falling-edge enable (address 1) set, a 1-to-0 transition of the synchronised pin sets status bit n. The bit stays set until software clears it.
- R5: With both the rising and the falling enable set for pin n, each transition in either direction sets status bit n.
- R6: With bit n of the high-level enable (address 2) set, status bit n is set on every cycle the synchronised pin is 1. A clear written while the pin is high does not hold. A clear written after the pin has gone low clears the bit.
- R7: With bit n of the low-level enable (address 3) set, status bit n is set on every cycle the synchronised pin is 0. A clear written while the pin is low does not hold. A clear written after the pin has gone high clears the bit.
- R8: Writing to the status register (address 4) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R9: If an event for pin n occurs in the same cycle as a clear of status bit n, the bit stays set.
- R10: `irq` is registered. It rises one cycle after the status register becomes non-zero, and falls one cycle after the status register becomes all zero.
- R11: Clearing an enable bit leaves an already-set status bit unchanged.
- R12: A pin whose four enables are all zero never sets its status bit, whatever it does.
- R13: Pins at or above `NUM_PRESENT` do not exist. Their enable and status bits read as zero and never take part in `irq`.
- R14: The four enable registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Asynchronous pin levels, pin n on bit n |
| reg_we | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | NPINS | Register write data |
| reg_rdata | output | NPINS | Combinational read data for `reg_addr` |
| irq | output | 1 | Bank interrupt, registered OR of all status bits |

## Verification
The bench targets three collisions:
- **Clear while a level is held.** It writes a clear while an armed level is still present, and writes another after the pin has de-asserted. A design that treated level events like edges would drop the bit on the first clear. A design that latched level events would keep the bit after the second.
- **Clear on the cycle an edge arrives.** It clears a status bit on exactly the cycle a new edge is detected. A design that gives the clear priority loses that event.
- **Partial writes and enable changes.** It writes zero bits and partial masks to the status register, and turns enables off after events have been recorded. This exposes designs that clear too many bits or that clear status when an enable changes.

Synchroniser depth and `irq` latency are checked cycle by cycle. A 22-pin instance confirms that the missing pins stay silent.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_RISE_EN = 3'd0,
        REG_FALL_EN = 3'd1,
        REG_HIGH_EN = 3'd2,
        REG_LOW_EN  = 3'd3,
        REG_STATUS  = 3'd4,
        REG_LEVEL   = 3'd5
    } reg_sel_e;

    localparam int N_ENABLES = 4;

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] prev_out
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
    assign prev_out = prev_q;

    // R2: the delayed copy trails the synchronised level by exactly one cycle
    assert_prev_trails_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_out == $past(sync_out)))
        else $error("prev_out does not trail sync_out");

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int                WIDTH        = 32,
    parameter logic [WIDTH-1:0]  PRESENT_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] prev,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] high_en,
    input  logic [WIDTH-1:0] low_en,
    output logic [WIDTH-1:0] evt
);

    logic [WIDTH-1:0] rise_w;
    logic [WIDTH-1:0] fall_w;

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        if (PRESENT_MASK[p]) begin : g_live
            assign rise_w[p] = lvl[p] & ~prev[p];
            assign fall_w[p] = ~lvl[p] & prev[p];
            assign evt[p]    = (rise_en[p] & rise_w[p])
                             | (fall_en[p] & fall_w[p])
                             | (high_en[p] & lvl[p])
                             | (low_en[p]  & ~lvl[p]);
        end else begin : g_absent
            assign rise_w[p] = 1'b0;
            assign fall_w[p] = 1'b0;
            assign evt[p]    = 1'b0;
        end
    end

    // R3: a rising edge is seen for one cycle only
    assert_rise_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_w) |=> ((rise_w & $past(rise_w)) == '0))
        else $error("rising edge seen twice");

    // R4: a falling edge is seen for one cycle only
    assert_fall_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_w) |=> ((fall_w & $past(fall_w)) == '0))
        else $error("falling edge seen twice");

    // R12: no event on a pin with all enables off
    assert_no_enable_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> ((evt & ~(rise_en | fall_en | high_en | low_en)) == '0))
        else $error("event without enable");

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int                WIDTH        = 32,
    parameter logic [WIDTH-1:0]  PRESENT_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  evt,
    input  logic [WIDTH-1:0]  lvl,
    output logic [WIDTH-1:0]  rise_en,
    output logic [WIDTH-1:0]  fall_en,
    output logic [WIDTH-1:0]  high_en,
    output logic [WIDTH-1:0]  low_en,
    output logic              irq
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] en_q [N_ENABLES];
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] status_d;
    logic [WIDTH-1:0] clr_mask;
    logic             irq_q;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        clr_mask = '0;
        if (reg_we && sel == REG_STATUS) clr_mask = reg_wdata;
        status_d = ((status_q & ~clr_mask) | evt) & PRESENT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENABLES; i++) en_q[i] <= '0;
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (reg_we) begin
                unique case (sel)
                    REG_RISE_EN: en_q[0] <= reg_wdata & PRESENT_MASK;
                    REG_FALL_EN: en_q[1] <= reg_wdata & PRESENT_MASK;
                    REG_HIGH_EN: en_q[2] <= reg_wdata & PRESENT_MASK;
                    REG_LOW_EN:  en_q[3] <= reg_wdata & PRESENT_MASK;
                    default: ;
                endcase
            end
            status_q <= status_d;
            irq_q    <= |status_q;
        end
    end

    always_comb begin
        unique case (sel)
            REG_RISE_EN: reg_rdata = en_q[0];
            REG_FALL_EN: reg_rdata = en_q[1];
            REG_HIGH_EN: reg_rdata = en_q[2];
            REG_LOW_EN:  reg_rdata = en_q[3];
            REG_STATUS:  reg_rdata = status_q;
            REG_LEVEL:   reg_rdata = lvl;
            default:     reg_rdata = '0;
        endcase
    end

    assign rise_en = en_q[0];
    assign fall_en = en_q[1];
    assign high_en = en_q[2];
    assign low_en  = en_q[3];
    assign irq     = irq_q;

    // R8: bits written as one, with no new event, are clear afterwards
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && sel == REG_STATUS) |=> ((status_q & $past(reg_wdata & ~evt)) == '0))
        else $error("write-one did not clear");

    // R8: a status bit only falls where a one was written
    assert_zero_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0))
        else $error("status bit lost without clear");

    // R9: an event always lands in status, even against a clear
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status_q & $past(evt)) == $past(evt)))
        else $error("event lost");

    // R10: interrupt tracks non-empty status one cycle later
    assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |=> irq)
        else $error("irq missing");
    assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |=> !irq)
        else $error("spurious irq");

    // R13: absent pins hold no state
    assert_absent_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> (((status_q | en_q[0] | en_q[1] | en_q[2] | en_q[3]) & ~PRESENT_MASK) == '0))
        else $error("absent pin has state");

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int NUM_PRESENT = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq
);

    localparam logic [NPINS-1:0] PRESENT_MASK = {NPINS{1'b1}} >> (NPINS - NUM_PRESENT);

    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] prev;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] rise_en;
    logic [NPINS-1:0] fall_en;
    logic [NPINS-1:0] high_en;
    logic [NPINS-1:0] low_en;

    gpio_evt_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl),
        .prev_out (prev)
    );

    gpio_evt_detect #(.WIDTH(NPINS), .PRESENT_MASK(PRESENT_MASK)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .prev    (prev),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .high_en (high_en),
        .low_en  (low_en),
        .evt     (evt)
    );

    gpio_evt_regs #(.WIDTH(NPINS), .PRESENT_MASK(PRESENT_MASK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .lvl       (lvl),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .high_en   (high_en),
        .low_en    (low_en),
        .irq       (irq)
    );

endmodule

// File: tb/tb_gpio_evt_bank.sv
`timescale 1ns/1ps
module tb_gpio_evt_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [31:0] hi_rdata;
    logic        hi_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    localparam logic [2:0] A_RISE = 3'd0, A_FALL = 3'd1, A_HIGH = 3'd2,
                           A_LOW = 3'd3, A_STAT = 3'd4, A_LVL = 3'd5;

    always #2 clk = ~clk;

    gpio_evt_bank dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    gpio_evt_bank #(.NUM_PRESENT(22)) dut_hi (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(hi_rdata), .irq(hi_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic cleanup();
        wr(A_RISE, 0); wr(A_FALL, 0); wr(A_HIGH, 0); wr(A_LOW, 0);
        pins = '0;
        step(3);
        wr(A_STAT, 32'hFFFF_FFFF);
        step(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset irq", {31'd0, irq}, 0);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        pins[0] = 1'b1;
        step(1);
        rd(A_LVL, v); check("R2 level after one edge", v, 0);
        step(1);
        rd(A_LVL, v); check("R2 level after two edges", v, 32'h1);
        wr(A_LVL, 32'h0);
        rd(A_LVL, v); check("R2 level write ignored", v, 32'h1);
        cleanup();
    endtask

    task automatic t_enable_rb();
        logic [31:0] v;
        wr(A_RISE, 32'h1234_5678); wr(A_FALL, 32'h8765_4321);
        wr(A_HIGH, 32'hF0F0_0000); wr(A_LOW, 32'h0000_0F0F);
        rd(A_RISE, v); check("R14 rise enable readback", v, 32'h1234_5678);
        rd(A_FALL, v); check("R14 fall enable readback", v, 32'h8765_4321);
        rd(A_HIGH, v); check("R14 high enable readback", v, 32'hF0F0_0000);
        rd(A_LOW, v);  check("R14 low enable readback", v, 32'h0000_0F0F);
        wr(A_HIGH, 0); wr(A_LOW, 0);
        cleanup();
    endtask

    task automatic t_rise_irq();
        logic [31:0] v;
        wr(A_RISE, 32'h1);
        pins[0] = 1'b1;
        step(3);
        rd(A_STAT, v); check("R3 rise sets status", v, 32'h1);
        check("R10 irq still low when status first set", {31'd0, irq}, 0);
        step(1);
        check("R10 irq one cycle after status", {31'd0, irq}, 1);
        step(2);
        rd(A_STAT, v); check("R3 rise status held", v, 32'h1);
        pins[0] = 1'b0;
        step(3);
        rd(A_STAT, v); check("R3 status sticky after fall", v, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); check("R3 cleared", v, 0);
        check("R10 irq lags clear", {31'd0, irq}, 1);
        step(1);
        check("R10 irq falls", {31'd0, irq}, 0);
        step(3);
        rd(A_STAT, v); check("R3 no re-set on steady pin", v, 0);
        cleanup();
    endtask

    task automatic t_fall();
        logic [31:0] v;
        pins[5] = 1'b1;
        step(3);
        wr(A_FALL, 32'h20);
        rd(A_STAT, v); check("R4 no status before fall", v, 0);
        pins[5] = 1'b0;
        step(3);
        rd(A_STAT, v); check("R4 fall sets status", v, 32'h20);
        cleanup();
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(A_RISE, 32'h40); wr(A_FALL, 32'h40);
        pins[6] = 1'b1;
        step(3);
        rd(A_STAT, v); check("R5 both-edge rise", v, 32'h40);
        wr(A_STAT, 32'h40);
        pins[6] = 1'b0;
        step(3);
        rd(A_STAT, v); check("R5 both-edge fall", v, 32'h40);
        cleanup();
    endtask

    task automatic t_high();
        logic [31:0] v;
        wr(A_HIGH, 32'h100);
        pins[8] = 1'b1;
        step(3);
        rd(A_STAT, v); check("R6 high level sets", v, 32'h100);
        wr(A_STAT, 32'h100);
        rd(A_STAT, v); check("R6 clear while high does not hold", v, 32'h100);
        pins[8] = 1'b0;
        step(2);
        wr(A_STAT, 32'h100);
        rd(A_STAT, v); check("R6 clear after de-assert", v, 0);
        cleanup();
    endtask

    task automatic t_low();
        logic [31:0] v;
        wr(A_LOW, 32'h80);
        step(1);
        rd(A_STAT, v); check("R7 low level sets", v, 32'h80);
        wr(A_STAT, 32'h80);
        rd(A_STAT, v); check("R7 clear while low does not hold", v, 32'h80);
        pins[7] = 1'b1;
        step(2);
        wr(A_STAT, 32'h80);
        rd(A_STAT, v); check("R7 clear after de-assert", v, 0);
        cleanup();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_RISE, 32'h6);
        pins[2:1] = 2'b11;
        step(3);
        rd(A_STAT, v); check("R8 two bits set", v, 32'h6);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R8 zero write keeps bits", v, 32'h6);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); check("R8 one bit cleared", v, 32'h4);
        cleanup();
    endtask

    task automatic t_evt_wins();
        logic [31:0] v;
        wr(A_RISE, 32'h10);
        pins[4] = 1'b1;
        step(3);
        pins[4] = 1'b0;
        step(3);
        rd(A_STAT, v); check("R9 first edge recorded", v, 32'h10);
        pins[4] = 1'b1;
        step(2);
        wr(A_STAT, 32'h10);
        rd(A_STAT, v); check("R9 event beats clear", v, 32'h10);
        wr(A_STAT, 32'h10);
        rd(A_STAT, v); check("R9 later clear holds", v, 0);
        cleanup();
    endtask

    task automatic t_en_clear();
        logic [31:0] v;
        wr(A_RISE, 32'h4);
        pins[2] = 1'b1;
        step(3);
        wr(A_RISE, 32'h0);
        rd(A_STAT, v); check("R11 status kept after enable cleared", v, 32'h4);
        cleanup();
    endtask

    task automatic t_no_en();
        logic [31:0] v;
        pins[9] = 1'b1;
        step(3);
        pins[9] = 1'b0;
        step(3);
        rd(A_STAT, v); check("R12 no enable no status", v, 0);
        check("R12 no enable no irq", {31'd0, irq}, 0);
        cleanup();
    endtask

    task automatic t_absent();
        logic [31:0] v;
        wr(A_RISE, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_RISE, v);
        check("R13 absent enables read zero", hi_rdata, 32'h003F_FFFF);
        pins = 32'hFFFF_FFFF;
        step(3);
        rd(A_STAT, v);
        check("R13 absent status bits zero", hi_rdata, 32'h003F_FFFF);
        check("R13 full bank status", v, 32'hFFFF_FFFF);
        wr(A_RISE, 32'hFFC0_0000);
        wr(A_STAT, 32'hFFFF_FFFF);
        pins = '0;
        step(3);
        pins = 32'hFFC0_0000;
        step(4);
        check("R13 absent pins raise no irq", {31'd0, hi_irq}, 0);
        cleanup();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_sync();
        t_enable_rb();
        t_rise_irq();
        t_fall();
        t_both();
        t_high();
        t_low();
        t_w1c();
        t_evt_wins();
        t_en_clear();
        t_no_en();
        t_absent();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule